// File: doc/BRIEF.md
# Bit-Field Set, Clear, Toggle and Extract Unit

This unit performs one 32-bit bit-field operation per request and returns the result one clock later. A request carries an operand, a second source word, an operation code and two 5-bit field parameters. It can clear or set a contiguous run of bits, invert bits by XOR with the second source, or pull out a contiguous field as an unsigned, right-justified value.

The two field parameters, A and B, either come from immediate inputs or are taken at run time from the second source word. Set and clear read A as the most significant bit of the field and B as its least significant bit. Extract reads A as a left-shift amount and B as a logical right-shift amount. The operand is shifted left by A and then right by B, so B must already count the A bits dropped on the left. Setting A to 8 and B to 24 therefore selects bits 23..16.

Top module: `bfu_unit`

## Requirements
- R1: While rst is high and in the first cycle after it, out_valid is 0 and result is 0.
- R2: Clear (op_sel = 0) forces bits A down to B of the operand to 0. With A=31 and B=24, 12345555h gives 00345555h.
- R3: Set (op_sel = 1) forces bits A down to B of the operand to 1. With A=23 and B=16, 00345555h gives 00FF5555h.
- R4: Toggle (op_sel = 2) returns operand XOR src2. An all-ones src2 turns 00FF5555h into FF00AAAAh.
- R5: Extract (op_sel = 3) returns (operand << A) >> B, zero-filled. From 12345555h, A=8 with B=24 gives 00000034h, and A=0 with B=24 gives 00000012h.
- R6: For set and clear, when A is below B the operand is returned unchanged.
- R7: When use_reg_param is 1, A is taken from src2[9:5] and B from src2[4:0], and imm_a and imm_b are ignored.
- R8: The result appears with out_valid in the cycle after in_valid. out_valid is high for exactly one cycle per request. result keeps its last value while no request is accepted.
- R9: Bounds cover every position from 0 to 31. Set with A=31 and B=0 gives all ones. Clear with A=0 and B=0 clears only bit 0. Extract with A=0 and B=0 returns the operand.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Request strobe |
| op_sel | input | 2 | 0 clear, 1 set, 2 toggle, 3 extract |
| operand | input | 32 | Data word to operate on |
| src2 | input | 32 | XOR operand; also carries run-time A and B |
| use_reg_param | input | 1 | 1: A and B come from src2, 0: from immediates |
| imm_a | input | 5 | Immediate A (field MSB, or left shift) |
| imm_b | input | 5 | Immediate B (field LSB, or right shift) |
| result | output | 32 | Registered result |
| out_valid | output | 1 | One-cycle strobe marking a new result |

## Verification
The unit holds no state beyond its output register, so every fault shows up at the ports one cycle after the request that exposes it. A mask built with the wrong bounds shows as wrong bits inside or next to the field. Choosing the wrong parameter source shows as a result that follows the immediates instead of src2. A faulty valid or hold register shows in the idle cycle after a request, as a stray strobe or a changed result. The tests place fields at both ends of the word, use inverted bounds and send requests back to back, so that such faults cannot stay hidden.

// File: rtl/bfu_pkg.sv
package bfu_pkg;
  localparam int DATA_W = 32;
  localparam int POS_W  = $clog2(DATA_W);

  typedef enum logic [1:0] {
    BF_CLR = 2'd0,
    BF_SET = 2'd1,
    BF_XOR = 2'd2,
    BF_EXT = 2'd3
  } bf_op_e;
endpackage

// File: rtl/bfu_param_mux.sv
module bfu_param_mux #(
  parameter int DATA_W = 32,
  parameter int POS_W  = 5
) (
  input  logic              use_reg,
  input  logic [DATA_W-1:0] reg_word,
  input  logic [POS_W-1:0]  imm_a,
  input  logic [POS_W-1:0]  imm_b,
  output logic [POS_W-1:0]  eff_a,
  output logic [POS_W-1:0]  eff_b
);
  localparam int A_LSB = POS_W;

  always_comb begin
    if (use_reg) begin
      eff_a = reg_word[A_LSB +: POS_W];
      eff_b = reg_word[0 +: POS_W];
    end else begin
      eff_a = imm_a;
      eff_b = imm_b;
    end
  end
endmodule

// File: rtl/bfu_mask_gen.sv
module bfu_mask_gen #(
  parameter int DATA_W = 32,
  parameter int POS_W  = 5
) (
  input  logic [POS_W-1:0]  msb,
  input  logic [POS_W-1:0]  lsb,
  output logic [DATA_W-1:0] mask
);
  for (genvar i = 0; i < DATA_W; i++) begin : g_bit
    assign mask[i] = (POS_W'(i) >= lsb) && (POS_W'(i) <= msb);
  end

  // R6
  always_comb begin
    if (msb < lsb) empty_mask_chk: assert (mask == '0);
  end
endmodule

// File: rtl/bfu_extract.sv
module bfu_extract #(
  parameter int DATA_W = 32,
  parameter int POS_W  = 5
) (
  input  logic [DATA_W-1:0] din,
  input  logic [POS_W-1:0]  lshift,
  input  logic [POS_W-1:0]  rshift,
  output logic [DATA_W-1:0] dout
);
  logic [DATA_W-1:0] left_stage;

  always_comb begin
    left_stage = din << lshift;
    dout       = left_stage >> rshift;
  end
endmodule

// File: rtl/bfu_unit.sv
module bfu_unit
  import bfu_pkg::*;
#(
  parameter int W  = DATA_W,
  parameter int PW = POS_W
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          in_valid,
  input  logic [1:0]    op_sel,
  input  logic [W-1:0]  operand,
  input  logic [W-1:0]  src2,
  input  logic          use_reg_param,
  input  logic [PW-1:0] imm_a,
  input  logic [PW-1:0] imm_b,
  output logic [W-1:0]  result,
  output logic          out_valid
);
  logic [PW-1:0] fa, fb;
  logic [W-1:0]  field_mask, ext_val, next_res;
  bf_op_e        op;

  assign op = bf_op_e'(op_sel);

  bfu_param_mux #(.DATA_W(W), .POS_W(PW)) u_pmux (
    .use_reg(use_reg_param), .reg_word(src2),
    .imm_a(imm_a), .imm_b(imm_b), .eff_a(fa), .eff_b(fb)
  );

  bfu_mask_gen #(.DATA_W(W), .POS_W(PW)) u_mask (
    .msb(fa), .lsb(fb), .mask(field_mask)
  );

  bfu_extract #(.DATA_W(W), .POS_W(PW)) u_ext (
    .din(operand), .lshift(fa), .rshift(fb), .dout(ext_val)
  );

  always_comb begin
    unique case (op)
      BF_CLR:  next_res = operand & ~field_mask;
      BF_SET:  next_res = operand | field_mask;
      BF_XOR:  next_res = operand ^ src2;
      default: next_res = ext_val;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      result    <= '0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) result <= next_res;
    end
  end

  // R1
  reset_quiet_chk: assert property (@(posedge clk) rst |=> (!out_valid && result == '0));
  // R8
  valid_follow_chk: assert property (@(posedge clk) disable iff (rst) in_valid |=> out_valid);
  // R8
  idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> (!out_valid && $stable(result)));
  // R2
  clear_no_set_chk: assert property (@(posedge clk) disable iff (rst)
    (in_valid && op == BF_CLR) |=> ((result & ~$past(operand)) == '0));
  // R3
  set_no_clear_chk: assert property (@(posedge clk) disable iff (rst)
    (in_valid && op == BF_SET) |=> ((~result & $past(operand)) == '0));
  // R5
  extract_width_chk: assert property (@(posedge clk) disable iff (rst)
    (in_valid && op == BF_EXT && fa <= fb) |=>
    ((result >> (W - int'($past(fb)))) == '0));
endmodule

// File: tb/bfu_unit_bench.sv
`timescale 1ns/1ps
module bfu_unit_bench;
  logic        clk = 0;
  logic        rst;
  logic        in_valid;
  logic [1:0]  op_sel;
  logic [31:0] operand, src2;
  logic        use_reg_param;
  logic [4:0]  imm_a, imm_b;
  logic [31:0] result;
  logic        out_valid;
  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  bfu_unit u_bfu_unit (
    .clk(clk), .rst(rst), .in_valid(in_valid), .op_sel(op_sel),
    .operand(operand), .src2(src2), .use_reg_param(use_reg_param),
    .imm_a(imm_a), .imm_b(imm_b), .result(result), .out_valid(out_valid)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %08h expected %08h", req, act, exp);
    end
  endtask

  // One request, then one idle cycle checking the strobe and the hold (R8)
  task automatic run_op(input string req, input logic [1:0] op, input logic [31:0] a_word,
                        input logic [31:0] s2, input logic ureg, input logic [4:0] ia,
                        input logic [4:0] ib, input logic [31:0] exp);
    @(negedge clk);
    in_valid = 1; op_sel = op; operand = a_word; src2 = s2;
    use_reg_param = ureg; imm_a = ia; imm_b = ib;
    @(posedge clk); #1;
    check(req, result, exp);
    check({req, " R8 valid"}, {31'd0, out_valid}, 32'd1);
    @(negedge clk);
    in_valid = 0; operand = 32'hDEADBEEF; imm_a = 5'd31; imm_b = 5'd0;
    @(posedge clk); #1;
    check("R8 strobe drop", {31'd0, out_valid}, 32'd0);
    check("R8 hold", result, exp);
  endtask

  task automatic test_reset;
    rst = 1; in_valid = 0; op_sel = 0; operand = 0; src2 = 0;
    use_reg_param = 0; imm_a = 0; imm_b = 0;
    repeat (3) @(posedge clk);
    #1;
    check("R1 valid", {31'd0, out_valid}, 32'd0);
    check("R1 result", result, 32'd0);
    @(negedge clk); rst = 0;
  endtask

  task automatic test_clear_set_toggle;
    run_op("R2 clear 31:24", 2'd0, 32'h12345555, 0, 0, 5'd31, 5'd24, 32'h00345555);
    run_op("R3 set 23:16",   2'd1, 32'h00345555, 0, 0, 5'd23, 5'd16, 32'h00FF5555);
    run_op("R4 toggle",      2'd2, 32'h00FF5555, 32'hFFFFFFFF, 0, 0, 0, 32'hFF00AAAA);
    run_op("R4 toggle mask", 2'd2, 32'h0000F0F0, 32'h00FF00FF, 0, 0, 0, 32'h00FFF00F);
  endtask

  task automatic test_extract;
    run_op("R5 extract 34", 2'd3, 32'h12345555, 0, 0, 5'd8, 5'd24, 32'h00000034);
    run_op("R5 extract 12", 2'd3, 32'h12345555, 0, 0, 5'd0, 5'd24, 32'h00000012);
  endtask

  task automatic test_inverted;
    run_op("R6 clear inverted", 2'd0, 32'h12345555, 0, 0, 5'd3, 5'd10, 32'h12345555);
    run_op("R6 set inverted",   2'd1, 32'h12345555, 0, 0, 5'd3, 5'd10, 32'h12345555);
  endtask

  task automatic test_reg_param;
    // A = 8 in src2[9:5], B = 24 in src2[4:0]; the immediates hold other values
    run_op("R7 extract via reg", 2'd3, 32'h12345555, {22'd0, 5'd8, 5'd24}, 1, 5'd0, 5'd0, 32'h00000034);
    run_op("R7 set via reg",     2'd1, 32'h00000000, {22'd0, 5'd7, 5'd0},  1, 5'd31, 5'd31, 32'h000000FF);
  endtask

  task automatic test_bounds;
    run_op("R9 set full",     2'd1, 32'h00000000, 0, 0, 5'd31, 5'd0, 32'hFFFFFFFF);
    run_op("R9 clear bit0",   2'd0, 32'hFFFFFFFF, 0, 0, 5'd0, 5'd0, 32'hFFFFFFFE);
    run_op("R9 extract none", 2'd3, 32'hA5C3E7F1, 0, 0, 5'd0, 5'd0, 32'hA5C3E7F1);
  endtask

  task automatic test_back_to_back;
    @(negedge clk);
    in_valid = 1; op_sel = 2'd1; operand = 32'h0; use_reg_param = 0; imm_a = 5'd3; imm_b = 5'd0;
    @(posedge clk); #1;
    check("R8 b2b first", result, 32'h0000000F);
    @(negedge clk);
    op_sel = 2'd0; operand = 32'hFFFFFFFF; imm_a = 5'd31; imm_b = 5'd28;
    @(posedge clk); #1;
    check("R8 b2b second", result, 32'h0FFFFFFF);
    check("R8 b2b valid", {31'd0, out_valid}, 32'd1);
    @(negedge clk); in_valid = 0;
    @(posedge clk); #1;
    check("R8 b2b drop", {31'd0, out_valid}, 32'd0);
  endtask

  initial begin
    test_reset();
    test_clear_set_toggle();
    test_extract();
    test_inverted();
    test_reg_param();
    test_bounds();
    test_back_to_back();
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: actual hung expected done");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule